// File: doc/BRIEF.md
# Nonvolatile Command Sequence Controller

This controller sits between an asynchronous-style SRAM bus and the SRAM array of a memory with a nonvolatile shadow. It watches the read accesses on the bus and looks for a fixed, ordered chain of six reads. The first five reads must hit a fixed set of unlock addresses. The sixth read then picks a command: save the SRAM contents to the nonvolatile cells, reload the SRAM from them, or switch off automatic saving. Any write, or a read to an address that does not fit the chain, abandons the chain. Every read in the chain is an ordinary read, so the array keeps returning data while the controller listens.

Once a save or reload starts, the controller closes the array to the bus, pulls its active-low busy output low and steps through two timed phases. A save erases and then programs. A reload clears and then transfers. After a save, busy is released but access stays closed for a further hold-off time. Reset acts as power-up and starts a reload at once. Every phase length is a cycle count fixed by a parameter.

Top module: `nv_seq_ctrl`

## Requirements
- R1: During reset and after its release, busy_n is 0 and op_phase is 3 (clear). The clear and transfer phases then take T_CLR+T_XFER clocks in total, and the controller ends idle (op_phase 0) with as_disabled at 0.
- R2: Six reads, at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, start a save. In the clock after the sixth read, op_phase is 1 (erase) and busy_n is 0.
- R3: The same five unlock reads followed by a read at 0x0C63 start a reload, which shows op_phase 3 (clear) and then 4 (transfer).
- R4: The five unlock reads followed by a read at 0x0B45 set as_disabled without making busy_n low. The flag stays set until reset.
- R5: Only address bits 13:0 are compared. Bit 14 has no effect on matching.
- R6: A write access (ce_n and we_n low) during the chain abandons it, and no command runs.
- R7: A read at any address that does not fit the chain abandons it. This includes a wrong sixth address. No command runs.
- R8: A read that breaks the chain but is at 0x0E38 counts as the first step of a new chain.
- R9: A read counts when its qualifier becomes active: oe_n falling while ce_n is low, or ce_n falling while oe_n is low, with we_n high. A read held active over several clocks counts once.
- R10: A save holds op_phase 1 (erase) for T_ERASE clocks and then 2 (program) for T_PROG clocks, with busy_n 0 for all T_ERASE+T_PROG clocks.
- R11: After the program phase, busy_n returns to 1 and op_phase is 5 (hold-off) for T_INH clocks, with access_en 0. The controller then returns to idle.
- R12: While op_phase is not 0, access_en is 0 and bus accesses are ignored. A full command chain given during that time has no effect.
- R13: done is high for exactly one clock when a save or reload ends, in the clock in which busy_n returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| addr | input | 15 | Bus address |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| busy_n | output | 1 | Active-low busy, low during save and reload phases |
| access_en | output | 1 | High when the SRAM array may serve the bus |
| op_phase | output | 3 | 0 idle, 1 erase, 2 program, 3 clear, 4 transfer, 5 hold-off |
| done | output | 1 | One-clock pulse at the end of a save or reload |
| as_disabled | output | 1 | Sticky automatic-save disable flag |

## Verification
On every clock, the assertions check the legal phase order: erase leads to program, and program leads to hold-off. They also check that an operation begins only from idle, that done lasts one clock and coincides with busy_n rising, and that the disable flag never clears outside reset. Only the bench scenarios can show which address chains start which command and which ones abort. They also cover the masking of bit 14, the single count for a held read, the restart at 0x0E38, that commands given while busy are ignored, and the exact phase lengths.

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl #(
  parameter int AW      = 15,
  parameter int CW      = 14,
  parameter int TW      = 16,
  parameter int T_ERASE = 20,
  parameter int T_PROG  = 30,
  parameter int T_CLR   = 8,
  parameter int T_XFER  = 12,
  parameter int T_INH   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  output logic          busy_n,
  output logic          access_en,
  output logic [2:0]    op_phase,
  output logic          done,
  output logic          as_disabled
);

  localparam logic [2:0] PH_IDLE = 3'd0, PH_ERASE = 3'd1, PH_PROG = 3'd2,
                         PH_CLR  = 3'd3, PH_XFER  = 3'd4, PH_INH  = 3'd5;
  localparam logic [CW-1:0] K0 = CW'(14'h0E38), K1 = CW'(14'h31C7), K2 = CW'(14'h03E0),
                            K3 = CW'(14'h3C1F), K4 = CW'(14'h303F);
  localparam logic [CW-1:0] CMD_SAVE = CW'(14'h0FC0), CMD_LOAD = CW'(14'h0C63),
                            CMD_NOAS = CW'(14'h0B45);

  logic [2:0]    ph, step;
  logic [TW-1:0] cnt;
  logic          rd_q, wr_q, noas;

  function automatic logic [CW-1:0] key_at(input logic [2:0] i);
    case (i)
      3'd0:    key_at = K0;
      3'd1:    key_at = K1;
      3'd2:    key_at = K2;
      3'd3:    key_at = K3;
      default: key_at = K4;
    endcase
  endfunction

  wire          rd_act = !ce_n && !oe_n && we_n;
  wire          wr_act = !ce_n && !we_n;
  wire          idle   = (ph == PH_IDLE);
  wire          rd_ev  = idle && rd_act && !rd_q;
  wire          wr_ev  = idle && wr_act && !wr_q;
  wire [CW-1:0] a      = addr[CW-1:0];
  wire          last   = (step == 3'd5);
  wire          go_save = rd_ev && last && (a == CMD_SAVE);
  wire          go_load = rd_ev && last && (a == CMD_LOAD);
  wire          go_noas = rd_ev && last && (a == CMD_NOAS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !idle || wr_ev)
      step <= 3'd0;
    else if (rd_ev) begin
      if (!last && a == key_at(step)) step <= step + 3'd1;
      else if (a == K0)               step <= 3'd1;
      else                            step <= 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_CLR;
      cnt  <= TW'(T_CLR - 1);
      done <= 1'b0;
      noas <= 1'b0;
    end else begin
      done <= 1'b0;
      if (idle) begin
        if (go_save) begin
          ph  <= PH_ERASE;
          cnt <= TW'(T_ERASE - 1);
        end else if (go_load) begin
          ph  <= PH_CLR;
          cnt <= TW'(T_CLR - 1);
        end else if (go_noas)
          noas <= 1'b1;
      end else if (cnt != '0)
        cnt <= cnt - 1'b1;
      else begin
        case (ph)
          PH_ERASE: begin ph <= PH_PROG; cnt <= TW'(T_PROG - 1); end
          PH_PROG:  begin ph <= PH_INH;  cnt <= TW'(T_INH - 1); done <= 1'b1; end
          PH_CLR:   begin ph <= PH_XFER; cnt <= TW'(T_XFER - 1); end
          PH_XFER:  begin ph <= PH_IDLE; done <= 1'b1; end
          default:  ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy_n      = !(ph == PH_ERASE || ph == PH_PROG || ph == PH_CLR || ph == PH_XFER);
  assign access_en   = idle;
  assign op_phase    = ph;
  assign as_disabled = noas;

  // R10
  erase_then_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_phase == PH_ERASE) |=> (op_phase == PH_ERASE || op_phase == PH_PROG));
  // R11
  prog_then_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_phase == PH_PROG) |=> (op_phase == PH_PROG || op_phase == PH_INH));
  // R12
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(op_phase) == PH_IDLE));
  // R13
  done_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R13
  done_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(busy_n));
  // R4
  noas_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_disabled |=> as_disabled);

endmodule

// File: tb/nv_seq_ctrl_tb.sv
module nv_seq_ctrl_tb;
  localparam int T_ERASE = 20, T_PROG = 30, T_CLR = 8, T_XFER = 12, T_INH = 10;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic busy_n, access_en, done, as_disabled;
  logic [2:0] op_phase;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nv_seq_ctrl #(.T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_CLR(T_CLR),
                .T_XFER(T_XFER), .T_INH(T_INH)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy_n(busy_n), .access_en(access_en), .op_phase(op_phase), .done(done),
    .as_disabled(as_disabled));

  function automatic logic [13:0] key(input int i);
    case (i)
      0: key = 14'h0E38; 1: key = 14'h31C7; 2: key = 14'h03E0;
      3: key = 14'h3C1F; default: key = 14'h303F;
    endcase
  endfunction

  function automatic logic [13:0] cmd(input int op);
    case (op)
      0: cmd = 14'h0FC0; 1: cmd = 14'h0C63; default: cmd = 14'h0B45;
    endcase
  endfunction

  function automatic bit special(input logic [13:0] a);
    special = 0;
    for (int i = 0; i < 5; i++) if (a == key(i)) special = 1;
    for (int i = 0; i < 3; i++) if (a == cmd(i)) special = 1;
  endfunction

  function automatic int first_phase(input int op);
    first_phase = (op == 0) ? 1 : (op == 1) ? 3 : 0;
  endfunction

  function automatic int busy_len(input int op);
    busy_len = (op == 0) ? T_ERASE + T_PROG : (op == 1) ? T_CLR + T_XFER : 0;
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_rd(input logic [14:0] a, input bit via_oe, input int hold);
    @(negedge clk);
    addr = a; we_n = 1'b1;
    if (via_oe) ce_n = 1'b0; else oe_n = 1'b0;
    @(negedge clk);
    if (via_oe) oe_n = 1'b0; else ce_n = 1'b0;
    repeat (hold) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_wr(input logic [14:0] a);
    @(negedge clk);
    addr = a; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic send_cmd(input int op, input bit b14, input bit via_oe);
    for (int i = 0; i < 5; i++) do_rd({b14, key(i)}, via_oe, 1);
    do_rd({b14, cmd(op)}, via_oe, 1);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (busy_n == 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (op_phase != 3'd0) @(negedge clk);
  endtask

  task automatic quiet_check(input string r);
    repeat (3) @(negedge clk);
    chk(r, op_phase, 0);
    chk(r, busy_n, 1);
  endtask

  function automatic logic [13:0] noise();
    logic [13:0] a;
    a = 14'($urandom);
    while (special(a)) a = 14'($urandom);
    noise = a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n;
    bit exp_noas;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1 reset busy_n", busy_n, 0);
    chk("R1 reset phase", op_phase, 3);
    chk("R1 reset flag", as_disabled, 0);
    chk("R13 reset done", done, 0);
    rst_n = 1'b1;
    count_low(n);
    chk("R1 power-up reload length", n, T_CLR + T_XFER);
    chk("R13 done after reload", done, 1);
    chk("R1 idle after reload", op_phase, 0);
    @(negedge clk);
    chk("R13 done one clock", done, 0);

    send_cmd(0, 1'b0, 1'b0);
    chk("R2 save starts erase", op_phase, 1);
    chk("R12 access closed", access_en, 0);
    count_low(n);
    chk("R10 save busy length", n, T_ERASE + T_PROG);
    chk("R11 hold-off phase", op_phase, 5);
    chk("R11 hold-off access", access_en, 0);
    chk("R13 done after save", done, 1);
    n = 0;
    while (op_phase == 3'd5) begin n++; @(negedge clk); end
    chk("R11 hold-off length", n, T_INH);
    chk("R11 access back", access_en, 1);

    send_cmd(1, 1'b0, 1'b1);
    chk("R3 reload starts clear", op_phase, 3);
    repeat (T_CLR) @(negedge clk);
    chk("R3 reload transfer", op_phase, 4);
    count_low(n);
    chk("R3 reload remaining", n, T_XFER);
    chk("R3 idle", op_phase, 0);

    send_cmd(0, 1'b1, 1'b1);
    chk("R5 bit14 ignored", op_phase, 1);
    wait_idle();

    for (int i = 0; i < 3; i++) do_rd({1'b0, key(i)}, 1'b0, 1);
    do_wr({1'b0, key(3)});
    for (int i = 3; i < 5; i++) do_rd({1'b0, key(i)}, 1'b0, 1);
    do_rd({1'b0, cmd(0)}, 1'b0, 1);
    quiet_check("R6 write aborts");

    for (int i = 0; i < 5; i++) do_rd({1'b0, key(i)}, 1'b1, 1);
    do_rd(15'h0FC1, 1'b1, 1);
    quiet_check("R7 wrong sixth address");

    do_rd({1'b0, key(0)}, 1'b0, 1);
    do_rd({1'b0, key(1)}, 1'b0, 1);
    do_rd({1'b0, key(0)}, 1'b0, 1);
    for (int i = 1; i < 5; i++) do_rd({1'b0, key(i)}, 1'b0, 1);
    do_rd({1'b0, cmd(0)}, 1'b0, 1);
    chk("R8 restart at step 2", op_phase, 1);
    wait_idle();

    do_rd({1'b0, key(0)}, 1'b1, 1);
    do_rd({1'b0, key(1)}, 1'b1, 4);
    for (int i = 2; i < 5; i++) do_rd({1'b0, key(i)}, 1'b0, 2);
    do_rd({1'b0, cmd(1)}, 1'b1, 3);
    chk("R9 held read counts once", op_phase, 3);
    wait_idle();

    send_cmd(0, 1'b0, 1'b0);
    send_cmd(1, 1'b0, 1'b0);
    wait_idle();
    quiet_check("R12 command while busy ignored");

    send_cmd(2, 1'b0, 1'b0);
    chk("R4 disable flag set", as_disabled, 1);
    chk("R4 no busy", busy_n, 1);
    chk("R4 stays idle", op_phase, 0);
    send_cmd(0, 1'b0, 1'b1);
    wait_idle();
    chk("R4 flag sticky", as_disabled, 1);

    exp_noas = 1;
    for (int t = 0; t < 150; t++) begin
      int op, corr, p;
      bit b14, viaoe;
      op = int'($urandom % 3);
      corr = int'($urandom % 3);
      p = 1 + int'($urandom % 5);
      b14 = 1'($urandom);
      viaoe = 1'($urandom);
      for (int i = 0; i < 6; i++) begin
        if (corr == 1 && i == p) do_rd({1'($urandom), noise()}, 1'($urandom), 1);
        if (corr == 2 && i == p) do_wr({1'($urandom), key(i < 5 ? i : 4)});
        do_rd({b14, (i < 5) ? key(i) : cmd(op)}, viaoe, 1 + int'($urandom % 2));
      end
      if (corr == 0) begin
        if (op == 2) exp_noas = 1;
        chk(op == 0 ? "R2 random save" : op == 1 ? "R3 random reload" : "R4 random disable",
            op_phase, first_phase(op));
        chk("R10 random busy", busy_n, (busy_len(op) > 0) ? 0 : 1);
      end else begin
        chk(corr == 1 ? "R7 random abort read" : "R6 random abort write", op_phase, 0);
      end
      chk("R4 random flag", as_disabled, exp_noas);
      wait_idle();
    end

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset clears flag", as_disabled, 0);
    chk("R1 reset phase again", op_phase, 3);
    rst_n = 1'b1;
    wait_idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule